// File: doc/BRIEF.md
# BCD Seven-Segment Row Decoder with Zero Suppression

This block turns binary-coded decimal digits into drive levels for common-anode seven-segment LED displays. The levels are active low, so a low output lights its segment. A row of digits is built as one unit. Each digit has its own lamp-test and forced-blank controls. A ripple-blank signal passes from the most significant digit down the row. A zero that receives an asserted ripple-blank goes dark and passes the blank state to its lower neighbour, so leading zeros disappear and embedded zeros stay on.

The decode and the ripple chain are combinational. The whole row is sampled into output registers on each rising clock edge. A synchronous active-high reset darkens every digit. A parameter keeps the least significant digit from taking part in the chain, so a value of zero still shows a single "0".

Top module: `seg7_row`

## Requirements
- R1: Outputs are registered and show the inputs applied before the previous rising edge. While the synchronous active-high reset `rst` is high at an edge, every segment output and every ripple-blank output is driven high from that edge on.
- R2: With blank, lamp-test and ripple conditions inactive, codes 0 to 9 light these segments. Bit 0 is segment a, and bits run up to bit 6, which is segment g. A set bit below means the segment is lit, so the output bit is its complement. 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F (hex). Digit k occupies `seg_n_o[7k+6:7k]`.
- R3: When a digit's `bi_n_i` bit is low, its seven outputs are all high and its ripple-blank output is high, whatever its lamp-test, code and ripple input are.
- R4: When a digit's lamp test is low and its blank input is high, its seven outputs are all low and its ripple-blank output is high, whatever its code and ripple input are.
- R5: With blank and lamp test high, a digit whose code is 0000 and whose ripple input is low is dark and drives its ripple-blank output low. With a nonzero code, a low ripple input has no effect: the normal pattern is shown and the ripple-blank output stays high.
- R6: Codes 10 to 15, with blank and lamp test high, make all seven outputs high and the ripple-blank output high.
- R7: The most significant digit (index NUM_DIGITS-1) takes its ripple input from `rbi_n_i`. Each lower digit takes it from the ripple-blank result of the digit above, within the same cycle. Leading zeros are therefore blanked down to the first nonzero, lamp-tested or force-blanked digit.
- R8: With KEEP_LAST_ZERO=1 (the default) and more than one digit, digit 0 sees a high ripple input, so a row of all zeros shows one "0" in digit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bcd_i | input | NUM_DIGITS*4 | Digit codes, digit k at bits 4k+3:4k |
| lt_n_i | input | NUM_DIGITS | Lamp test per digit, active low |
| bi_n_i | input | NUM_DIGITS | Forced blank per digit, active low |
| rbi_n_i | input | 1 | Ripple-blank input of the most significant digit, active low |
| seg_n_o | output | NUM_DIGITS*7 | Registered segment drive, active low |
| rbo_n_o | output | NUM_DIGITS | Registered ripple-blank output per digit, active low |

## Verification
Forced blank, lamp test and ripple suppression can all be asserted on the same digit in the same cycle. The priority order then decides both the segments and the ripple-blank output. The bench provokes this by sweeping all sixteen codes against every combination of the three controls, applied to all four digits at once. It then adds random cycles in which zeros, lamp tests and blanks collide along the chain. Each registered result is judged one edge later against a bench model that walks the row from the top digit downward, applying the priority order at each digit.

// File: rtl/seg7_pkg.sv
package seg7_pkg;

  localparam int unsigned BCD_W = 4;
  localparam int unsigned SEG_W = 7;

  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;

  localparam seg_t SEG_DARK_N = '1;
  localparam seg_t SEG_FULL_N = '0;

  // Lit pattern, active high, bit 0 = segment a ... bit 6 = segment g.
  function automatic seg_t lit_pattern(input bcd_t code);
    seg_t p;
    case (code)
      4'd0:    p = 7'b0111111;
      4'd1:    p = 7'b0000110;
      4'd2:    p = 7'b1011011;
      4'd3:    p = 7'b1001111;
      4'd4:    p = 7'b1100110;
      4'd5:    p = 7'b1101101;
      4'd6:    p = 7'b1111101;
      4'd7:    p = 7'b0000111;
      4'd8:    p = 7'b1111111;
      4'd9:    p = 7'b1101111;
      default: p = 7'b0000000;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/seg7_digit_cell.sv
module seg7_digit_cell
  import seg7_pkg::*;
(
  input  bcd_t code_i,
  input  logic lt_n_i,
  input  logic bi_n_i,
  input  logic rbi_n_i,
  output seg_t seg_n_o,
  output logic rbo_n_o
);

  logic is_zero;
  assign is_zero = (code_i == '0);

  // Priority: forced blank, lamp test, ripple suppression, decode.
  always_comb begin
    seg_n_o = SEG_DARK_N;
    rbo_n_o = 1'b1;
    if (!bi_n_i) begin
      seg_n_o = SEG_DARK_N;
    end else if (!lt_n_i) begin
      seg_n_o = SEG_FULL_N;
    end else if (is_zero && !rbi_n_i) begin
      seg_n_o = SEG_DARK_N;
      rbo_n_o = 1'b0;
    end else begin
      seg_n_o = ~lit_pattern(code_i);
    end
  end

endmodule

// File: rtl/seg7_out_reg.sv
module seg7_out_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (rst) q_o <= '1;
    else     q_o <= d_i;
  end

endmodule

// File: rtl/seg7_row.sv
module seg7_row
  import seg7_pkg::*;
#(
  parameter int unsigned NUM_DIGITS     = 4,
  parameter bit          KEEP_LAST_ZERO = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_DIGITS*BCD_W-1:0]   bcd_i,
  input  logic [NUM_DIGITS-1:0]         lt_n_i,
  input  logic [NUM_DIGITS-1:0]         bi_n_i,
  input  logic                          rbi_n_i,
  output logic [NUM_DIGITS*SEG_W-1:0]   seg_n_o,
  output logic [NUM_DIGITS-1:0]         rbo_n_o
);

  localparam int unsigned SEG_BITS = NUM_DIGITS * SEG_W;
  localparam int unsigned TOP      = NUM_DIGITS - 1;

  logic [NUM_DIGITS-1:0] rbi_w;
  logic [NUM_DIGITS-1:0] rbo_w;
  logic [SEG_BITS-1:0]   seg_w;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
    if (k == TOP) begin : g_head
      assign rbi_w[k] = rbi_n_i;
    end else if (k == 0 && KEEP_LAST_ZERO) begin : g_keep
      assign rbi_w[k] = 1'b1;
    end else begin : g_link
      assign rbi_w[k] = rbo_w[k+1];
    end

    seg7_digit_cell u_cell (
      .code_i  (bcd_i[k*BCD_W +: BCD_W]),
      .lt_n_i  (lt_n_i[k]),
      .bi_n_i  (bi_n_i[k]),
      .rbi_n_i (rbi_w[k]),
      .seg_n_o (seg_w[k*SEG_W +: SEG_W]),
      .rbo_n_o (rbo_w[k])
    );

    AST_FORCE_BLANK: assert property (@(posedge clk) disable iff (rst)
      !bi_n_i[k] |=> (seg_n_o[k*SEG_W +: SEG_W] == SEG_DARK_N) && rbo_n_o[k]); // R3

    AST_LAMP_TEST: assert property (@(posedge clk) disable iff (rst)
      (bi_n_i[k] && !lt_n_i[k]) |=> (seg_n_o[k*SEG_W +: SEG_W] == SEG_FULL_N) && rbo_n_o[k]); // R4

    AST_RBO_DARK: assert property (@(posedge clk) disable iff (rst)
      !rbo_n_o[k] |-> (seg_n_o[k*SEG_W +: SEG_W] == SEG_DARK_N)); // R5

    AST_CODE_OOR: assert property (@(posedge clk) disable iff (rst)
      (bi_n_i[k] && lt_n_i[k] && (bcd_i[k*BCD_W +: BCD_W] > 4'd9))
        |=> (seg_n_o[k*SEG_W +: SEG_W] == SEG_DARK_N) && rbo_n_o[k]); // R6
  end

  seg7_out_reg #(.WIDTH(SEG_BITS)) u_seg_reg (
    .clk (clk),
    .rst (rst),
    .d_i (seg_w),
    .q_o (seg_n_o)
  );

  seg7_out_reg #(.WIDTH(NUM_DIGITS)) u_rbo_reg (
    .clk (clk),
    .rst (rst),
    .d_i (rbo_w),
    .q_o (rbo_n_o)
  );

  AST_RESET_DARK: assert property (@(posedge clk)
    rst |=> (seg_n_o == '1) && (rbo_n_o == '1)); // R1

endmodule

// File: tb/seg7_row_tb.sv
module seg7_row_tb;

  localparam int N        = 4;
  localparam int CLK_PER  = 10;
  localparam bit KEEP     = 1'b1;

  logic           clk = 1'b0;
  logic           rst;
  logic [N*4-1:0] bcd;
  logic [N-1:0]   lt_n;
  logic [N-1:0]   bi_n;
  logic           rbi_n;
  logic [N*7-1:0] seg_n;
  logic [N-1:0]   rbo_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  seg7_row #(.NUM_DIGITS(N), .KEEP_LAST_ZERO(KEEP)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .bcd_i   (bcd),
    .lt_n_i  (lt_n),
    .bi_n_i  (bi_n),
    .rbi_n_i (rbi_n),
    .seg_n_o (seg_n),
    .rbo_n_o (rbo_n)
  );

  function automatic logic [6:0] glyph(input logic [3:0] c);
    logic [6:0] g;
    case (c)
      4'd0: g = 7'h3F; 4'd1: g = 7'h06; 4'd2: g = 7'h5B; 4'd3: g = 7'h4F;
      4'd4: g = 7'h66; 4'd5: g = 7'h6D; 4'd6: g = 7'h7D; 4'd7: g = 7'h07;
      4'd8: g = 7'h7F; 4'd9: g = 7'h6F;
      default: g = 7'h00;
    endcase
    return g;
  endfunction

  task automatic model(output logic [N*7-1:0] es, output logic [N-1:0] er);
    logic       rb;
    logic [3:0] c;
    logic [6:0] s;
    logic       r;
    rb = rbi_n;
    for (int k = N-1; k >= 0; k--) begin
      c = bcd[k*4 +: 4];
      if (k == 0 && k != N-1 && KEEP) rb = 1'b1;
      if (!bi_n[k])                 begin s = 7'h7F;       r = 1'b1; end
      else if (!lt_n[k])            begin s = 7'h00;       r = 1'b1; end
      else if (c == 4'd0 && !rb)    begin s = 7'h7F;       r = 1'b0; end
      else                          begin s = ~glyph(c);   r = 1'b1; end
      es[k*7 +: 7] = s;
      er[k]        = r;
      rb           = r;
    end
  endtask

  task automatic check_row(input string tag);
    logic [N*7-1:0] es;
    logic [N-1:0]   er;
    model(es, er);
    @(negedge clk);
    checks++;
    if (seg_n !== es || rbo_n !== er) begin
      fails++;
      $display("FAIL %s: seg_n=%h rbo_n=%b expected seg_n=%h rbo_n=%b",
               tag, seg_n, rbo_n, es, er);
    end
  endtask

  task automatic set_all(input logic [3:0] c, input logic lt, input logic bi, input logic rb);
    for (int k = 0; k < N; k++) bcd[k*4 +: 4] = c;
    lt_n  = {N{lt}};
    bi_n  = {N{bi}};
    rbi_n = rb;
  endtask

  function automatic string tag_of(input logic [3:0] c, input logic lt, input logic bi, input logic rb);
    if (!bi)               return "R3";
    if (!lt)               return "R4";
    if (c > 4'd9)          return "R6";
    if (c == 4'd0 && !rb)  return "R5/R7";
    return "R2";
  endfunction

  initial begin
    int seed_val;
    seed_val = $urandom(32'd51873);
    rst = 1'b1;
    set_all(4'd8, 1'b0, 1'b1, 1'b1);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (seg_n !== '1 || rbo_n !== '1) begin
      fails++;
      $display("FAIL R1: seg_n=%h rbo_n=%b expected all ones", seg_n, rbo_n);
    end
    @(negedge clk);
    rst = 1'b0;
    check_row("R1 first cycle after reset");

    // Sweep every code against every control combination.
    for (int c = 0; c < 16; c++) begin
      for (int ctl = 0; ctl < 8; ctl++) begin
        set_all(c[3:0], ctl[2], ctl[1], ctl[0]);
        check_row(tag_of(c[3:0], ctl[2], ctl[1], ctl[0]));
      end
    end

    // Leading-zero chains, digit 3 is most significant.
    lt_n = '1; bi_n = '1; rbi_n = 1'b0;
    bcd = 16'h0000; check_row("R8 all zeros keep one zero");
    bcd = 16'h0050; check_row("R7 zeros above 5 blanked");
    bcd = 16'h0700; check_row("R7 embedded zeros shown");
    bcd = 16'h0A00; check_row("R7 code above nine stops chain");
    bcd = 16'h3000; check_row("R5 nonzero top digit");
    rbi_n = 1'b1; bcd = 16'h0000; check_row("R7 head ripple high no blanking");
    rbi_n = 1'b0; bcd = 16'h0000; lt_n = 4'b1011; check_row("R4 lamp test breaks chain");
    lt_n = '1; bi_n = 4'b1011; check_row("R3 forced blank breaks chain");
    bi_n = '1; lt_n = 4'b1011; bcd = 16'h0F00; check_row("R4 lamp test over code fifteen");

    // Random collisions of zeros, lamp test and blanking.
    for (int i = 0; i < 400; i++) begin
      for (int k = 0; k < N; k++) begin
        bcd[k*4 +: 4] = ($urandom_range(0, 1) == 0) ? 4'd0 : 4'($urandom_range(0, 15));
        lt_n[k] = ($urandom_range(0, 7) != 0);
        bi_n[k] = ($urandom_range(0, 7) != 0);
      end
      rbi_n = ($urandom_range(0, 3) != 0) ? 1'b0 : 1'b1;
      check_row("R2-R7 random");
    end

    // Reset in mid-operation.
    set_all(4'd8, 1'b1, 1'b1, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if (seg_n !== '1 || rbo_n !== '1) begin
      fails++;
      $display("FAIL R1: seg_n=%h rbo_n=%b expected all ones", seg_n, rbo_n);
    end
    rst = 1'b0;
    check_row("R2 eights after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule